// File: doc/BRIEF.md
# Power-Gated Cascaded 2/3-Cell Frequency Divider

This block is a cycle-accurate, synthesizable model of a programmable divider that is built as a chain of 2/3 divide cells and clocked by the fast input clock. A ratio word selects the division ratio. Its top bit chooses between a five-cell chain, which covers ratios 32 to 63, and a six-cell chain, which covers ratios 64 to 127. The block emits one single-cycle pulse per division cycle. It also exposes the modulus-feedback level of every cell.

The first cells of the chain hold the fast, power-hungry logic. For each of them the block derives a two-bit enable code for its end-of-cycle logic from the modulus levels of the two cells that follow it. That logic is therefore powered only during the short window at the end of each cycle in which it can make the cell swallow a period. A new ratio word takes effect only at a cycle boundary. This lets a fractional modulator alternate between the five-cell and six-cell lengths from one cycle to the next without a glitch.

Top module: `dmc_divider`

## Requirements
- R1: With ratio word bit 6 set, each division cycle lasts 64 + word[5:0] input clock cycles.
- R2: With ratio word bit 6 clear, each division cycle lasts 32 + word[4:0] input clock cycles, and bit 5 has no effect.
- R3: The ratio word is captured only on the clock edge that ends a division cycle (while `div_pulse` is high). A change of the word at any other time has no effect on the cycle in progress.
- R4: `div_pulse` is high for exactly one input cycle per division cycle, on the last cycle of that division cycle.
- R5: For a cell k below the last active cell, `stage_mod[k]` is high for the final 2^(k+1) + word[k:0] input cycles of every division cycle. Cell 4 follows the same rule with k = 4 in both configurations, so in the five-cell configuration it is high for the whole cycle. `stage_mod[5]` is high for the whole cycle in the six-cell configuration and never high in the five-cell configuration.
- R6: For gated cell m, `eoc_lc[m]` follows `stage_mod[m+2]` and `eoc_lp[m]` follows `stage_mod[m+1]`. Cell 0 is therefore enabled for 8 + 4·word[2] + 2·word[1] + word[0] input cycles per division cycle.
- R7: The code {eoc_lc[m], eoc_lp[m]} takes only the values 00 (off), 10 (waking) and 11 (on), never 01.
- R8: `eoc_swallow[m]` is low unless the code of cell m is 11. While the code is 11 it equals word[m], so an off cell always divides by 2.
- R9: Ratio words that alternate between the five-cell and six-cell configurations on successive cycles each produce their own exact cycle length.
- R10: While `rst_n` is low, `div_pulse`, every `stage_mod` bit and every enable code are 0. The first division cycle after release uses the word present at the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_in | input | NUM_CELLS+1 | Ratio word; the top bit selects the six-cell chain |
| div_pulse | output | 1 | One-cycle pulse at the end of each division cycle |
| stage_mod | output | NUM_CELLS | Modulus-feedback level of each cell |
| eoc_lc | output | NUM_GATED | Far enable bit of each gated cell's end-of-cycle logic |
| eoc_lp | output | NUM_GATED | Near enable bit of each gated cell's end-of-cycle logic |
| eoc_swallow | output | NUM_GATED | Swallow request of each gated cell, held low while not fully on |

## Verification
The bench sweeps every ratio from 32 to 127. This confirms the cycle length and shows that each bit weight of the word lands in the right place. A small table of hand-picked words adds cases that the sweep cannot separate: bit 5 toggled in the five-cell configuration must leave the length unchanged, and sparse and dense bit patterns make each cell's window length differ from its neighbours'. Directed runs alternate the five-cell and six-cell configurations on back-to-back cycles and change the word in mid-cycle. Another run asserts reset in the middle of a cycle. Together these separate boundary-only capture from immediate capture. In every cycle the enable windows and swallow windows are counted and compared against the expected lengths, and each cycle is checked for the forbidden 01 code.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   // Two-bit end-of-cycle enable code {far, near}; 2'b01 has no name on purpose.
   typedef enum logic [1:0] {
      EOC_OFF  = 2'b00,
      EOC_WAKE = 2'b10,
      EOC_ON   = 2'b11
   } eoc_mode_e;
endpackage

// File: rtl/dmc_cycle_ctr.sv
module dmc_cycle_ctr #(
   parameter int NC = 6,
   localparam int RW = NC + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [RW-1:0] ratio_in,
   output logic [RW-1:0] ratio_q,
   output logic [RW-1:0] remain,
   output logic          started,
   output logic          cycle_end
);
   logic [RW-1:0] len_in;

   // Long chain: 2^NC + low NC bits; short chain: 2^(NC-1) + low NC-1 bits.
   always_comb begin
      if (ratio_in[NC]) len_in = {1'b1, ratio_in[NC-1:0]};
      else              len_in = {2'b01, ratio_in[NC-2:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain  <= '0;
         ratio_q <= '0;
         started <= 1'b0;
      end else if (remain == '0) begin
         remain  <= len_in - RW'(1);
         ratio_q <= ratio_in;
         started <= 1'b1;
      end else begin
         remain  <= remain - RW'(1);
      end
   end

   assign cycle_end = started && (remain == '0);
endmodule

// File: rtl/dmc_stage.sv
module dmc_stage #(
   parameter int NC  = 6,
   parameter int IDX = 0,
   localparam int RW = NC + 1
) (
   input  logic          started,
   input  logic [RW-1:0] remain,
   input  logic [RW-1:0] ratio_q,
   output logic          mod_o
);
   logic six_cell;
   logic unused_sink;
   assign six_cell    = ratio_q[NC];
   assign unused_sink = ^{remain, ratio_q};

   generate
      if (IDX == NC - 1) begin : g_top_cell
         // Last cell of the long chain: its modulus input is tied active.
         assign mod_o = started & six_cell;
      end else begin : g_inner_cell
         logic [RW-1:0] win;
         assign win = RW'({1'b1, ratio_q[IDX:0]});
         if (IDX == NC - 2) begin : g_short_top
            // Terminal cell of the short chain, inner cell of the long one.
            assign mod_o = started & (six_cell ? (remain < win) : 1'b1);
         end else begin : g_plain
            assign mod_o = started & (remain < win);
         end
      end
   endgenerate
endmodule

// File: rtl/dmc_eoc_gate.sv
module dmc_eoc_gate
   import dmc_pkg::*;
(
   input  logic mod_near,
   input  logic mod_far,
   input  logic p_bit,
   output logic lc,
   output logic lp,
   output logic swallow
);
   eoc_mode_e mode;

   assign lc      = mod_far;
   assign lp      = mod_near;
   assign mode    = eoc_mode_e'({mod_far, mod_near});
   // Off or waking logic is clamped to the divide-by-2 level.
   assign swallow = (mode == EOC_ON) & p_bit;
endmodule

// File: rtl/dmc_divider.sv
module dmc_divider #(
   parameter int NUM_CELLS = 6,
   parameter int NUM_GATED = 2,
   localparam int RW = NUM_CELLS + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [RW-1:0]        ratio_in,
   output logic                 div_pulse,
   output logic [NUM_CELLS-1:0] stage_mod,
   output logic [NUM_GATED-1:0] eoc_lc,
   output logic [NUM_GATED-1:0] eoc_lp,
   output logic [NUM_GATED-1:0] eoc_swallow
);
   generate
      if (NUM_CELLS < 3) begin : g_bad_cells
         $error("dmc_divider: NUM_CELLS must be at least 3");
      end
      if (NUM_GATED < 1 || NUM_GATED > NUM_CELLS - 2) begin : g_bad_gated
         $error("dmc_divider: NUM_GATED must lie in 1..NUM_CELLS-2");
      end
   endgenerate

   logic [RW-1:0] ratio_q;
   logic [RW-1:0] remain;
   logic          started;

   dmc_cycle_ctr #(.NC(NUM_CELLS)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .ratio_in  (ratio_in),
      .ratio_q   (ratio_q),
      .remain    (remain),
      .started   (started),
      .cycle_end (div_pulse)
   );

   generate
      for (genvar k = 0; k < NUM_CELLS; k++) begin : g_cell
         dmc_stage #(.NC(NUM_CELLS), .IDX(k)) u_stage (
            .started (started),
            .remain  (remain),
            .ratio_q (ratio_q),
            .mod_o   (stage_mod[k])
         );
      end
      for (genvar m = 0; m < NUM_GATED; m++) begin : g_gate
         dmc_eoc_gate u_gate (
            .mod_near (stage_mod[m+1]),
            .mod_far  (stage_mod[m+2]),
            .p_bit    (ratio_q[m]),
            .lc       (eoc_lc[m]),
            .lp       (eoc_lp[m]),
            .swallow  (eoc_swallow[m])
         );
      end
   endgenerate
endmodule

// File: rtl/dmc_divider_chk.sv
module dmc_divider_chk #(
   parameter int NC = 6,
   parameter int NG = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          div_pulse,
   input logic [NC-1:0] stage_mod,
   input logic [NG-1:0] eoc_lc,
   input logic [NG-1:0] eoc_lp,
   input logic [NG-1:0] eoc_swallow,
   input logic [NC:0]   ratio_q
);
   assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);

   assert_end_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |-> stage_mod[0]);

   assert_short_top_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (div_pulse && !ratio_q[NC]) |-> !stage_mod[NC-1]);

   assert_word_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_mod[NC-2] && !div_pulse) |=> $stable(ratio_q));

   generate
      for (genvar k = 0; k < NC - 2; k++) begin : g_nest
         assert_window_nest_R5: assert property (@(posedge clk) disable iff (!rst_n)
            stage_mod[k] |-> stage_mod[k+1]);
      end
      for (genvar m = 0; m < NG; m++) begin : g_code
         assert_no_forbidden_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
            eoc_lp[m] |-> eoc_lc[m]);
         assert_swallow_when_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
            eoc_swallow[m] |-> (eoc_lc[m] && eoc_lp[m]));
      end
   endgenerate
endmodule

bind dmc_divider dmc_divider_chk #(.NC(NUM_CELLS), .NG(NUM_GATED)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .div_pulse   (div_pulse),
   .stage_mod   (stage_mod),
   .eoc_lc      (eoc_lc),
   .eoc_lp      (eoc_lp),
   .eoc_swallow (eoc_swallow),
   .ratio_q     (ratio_q)
);

// File: tb/dmc_divider_tb.sv
module dmc_divider_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] ratio_in = '0;
   logic       div_pulse;
   logic [5:0] stage_mod;
   logic [1:0] eoc_lc, eoc_lp, eoc_swallow;

   int compared = 0;
   int mismatched = 0;

   // {ratio word, expected cycle length}
   localparam logic [13:0] VEC [10] = '{
      {7'h00, 7'd32}, {7'h20, 7'd32}, {7'h3F, 7'd63}, {7'h1F, 7'd63},
      {7'h40, 7'd64}, {7'h7F, 7'd127}, {7'h55, 7'd85}, {7'h2A, 7'd42},
      {7'h60, 7'd96}, {7'h0D, 7'd45}
   };

   always #(CLK_PERIOD/2) clk = ~clk;

   dmc_divider u_dut (
      .clk (clk), .rst_n (rst_n), .ratio_in (ratio_in),
      .div_pulse (div_pulse), .stage_mod (stage_mod),
      .eoc_lc (eoc_lc), .eoc_lp (eoc_lp), .eoc_swallow (eoc_swallow)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int win(input int k, input logic [6:0] w);
      return (1 << (k+1)) + (int'(w) & ((1 << (k+1)) - 1));
   endfunction

   // Called at a negedge just before the clock edge that loads w.
   task automatic run_cycle(input logic [6:0] w, input int exp_n, input bit do_mid,
                            input logic [6:0] w_mid, input string tag);
      int n = 0;
      int modc [6] = '{default: 0};
      int lcc [2] = '{default: 0};
      int lpc [2] = '{default: 0};
      int swc [2] = '{default: 0};
      int bad01 = 0;
      ratio_in = w;
      do begin
         @(negedge clk);
         n++;
         if (do_mid && n == 10) ratio_in = w_mid;
         for (int k = 0; k < 6; k++) if (stage_mod[k]) modc[k]++;
         for (int m = 0; m < 2; m++) begin
            if (eoc_lc[m]) lcc[m]++;
            if (eoc_lp[m]) lpc[m]++;
            if (eoc_swallow[m]) swc[m]++;
            if (!eoc_lc[m] && eoc_lp[m]) bad01++;
         end
      end while (!div_pulse && n < 300);
      chk(n == exp_n, {tag, " cycle length"}, n, exp_n);
      for (int k = 0; k < 5; k++)
         chk(modc[k] == win(k, w), "R5 stage_mod window", modc[k], win(k, w));
      chk(modc[5] == (w[6] ? exp_n : 0), "R5 top cell window", modc[5], w[6] ? exp_n : 0);
      for (int m = 0; m < 2; m++) begin
         chk(lcc[m] == win(m+2, w), "R6 far enable window", lcc[m], win(m+2, w));
         chk(lpc[m] == win(m+1, w), "R6 near enable window", lpc[m], win(m+1, w));
         chk(swc[m] == (w[m] ? win(m+1, w) : 0), "R8 swallow window", swc[m],
             w[m] ? win(m+1, w) : 0);
      end
      chk(bad01 == 0, "R7 forbidden 01 code", bad01, 0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin : stim
      // R10: reset state
      repeat (3) @(negedge clk);
      chk(div_pulse == 1'b0, "R10 pulse in reset", div_pulse, 0);
      chk(stage_mod == '0, "R10 stage_mod in reset", stage_mod, 0);
      chk({eoc_lc, eoc_lp} == '0, "R10 codes in reset", {eoc_lc, eoc_lp}, 0);
      rst_n = 1'b1;
      run_cycle(7'h4A, 74, 1'b0, 7'h00, "R10 R1");

      // Table walk (R1, R2 including ignored bit 5)
      foreach (VEC[i])
         run_cycle(VEC[i][13:7], int'(VEC[i][6:0]),
                   1'b0, 7'h00, VEC[i][13] ? "R1" : "R2");

      // Full sweep of ratios 32..127
      for (int r = 32; r < 128; r++)
         run_cycle(r >= 64 ? 7'(r) : 7'(r - 32), r, 1'b0, 7'h00, r >= 64 ? "R1" : "R2");

      // R9: alternate short and long chains on successive cycles
      for (int i = 0; i < 4; i++) begin
         run_cycle(7'h0F, 47, 1'b0, 7'h00, "R9 R2");
         run_cycle(7'h41, 65, 1'b0, 7'h00, "R9 R1");
      end

      // R3: mid-cycle change ignored until the boundary
      run_cycle(7'h45, 69, 1'b1, 7'h03, "R3");
      run_cycle(7'h03, 35, 1'b1, 7'h7E, "R3");
      run_cycle(7'h7E, 126, 1'b0, 7'h00, "R3");

      // R10: reset in the middle of a cycle, then restart
      repeat (7) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(div_pulse == 1'b0, "R10 pulse after mid reset", div_pulse, 0);
      chk(stage_mod == '0, "R10 stage_mod after mid reset", stage_mod, 0);
      chk({eoc_lc, eoc_lp} == '0, "R10 codes after mid reset", {eoc_lc, eoc_lp}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      run_cycle(7'h1B, 59, 1'b0, 7'h00, "R10 R2");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule